// File: doc/BRIEF.md
# Tile-Triggered CHR Bank Mapper

This block is a cartridge memory mapper placed between an 8-bit CPU bus, the pattern-fetch address bus of a picture processor, and external program ROM, program RAM and character ROM. On the CPU side it decodes writes into bank-select registers. From those registers it forms the program ROM and RAM addresses and their chip enables. The upper 16 KB CPU window is always tied to the final ROM bank.

On the picture side, the 8 KB pattern space is split into two 4 KB halves. Each half has two candidate bank registers. A per-half tile latch chooses between them. The latch flips on its own when the picture processor fetches tiles $FD or $FE of its half, so a bank change can happen partway through a scanline with no CPU involvement. The block also drives the nametable RAM A10 line according to a software-selected mirroring mode.

Top module: `tile_bank_mapper`

## Requirements
- R1: After reset, both tile latches are in the FE state and all bank registers are zero. The mirroring bit is 0, which selects vertical.
- R2: CPU reads in $8000-$BFFF give ROM address {prg_bank, A13:0}. A write anywhere in $A000-$AFFF loads data bits 3:0 into prg_bank and ignores bits 7:4.
- R3: CPU addresses $C000-$FFFF always map to ROM bank 15, the last 16 KB of 256 KB: {4'hF, A13:0}.
- R4: prg_ram_ce_o is high only for $6000-$7FFF, with RAM address A12:0. prg_rom_ce_o is high only for $8000-$FFFF. The two enables are never high together.
- R5: Each write loads data bits 4:0 and ignores bits 7:5. The register is chosen by address: $B000-$BFFF loads lower/FD, $C000-$CFFF loads lower/FE, $D000-$DFFF loads upper/FD and $E000-$EFFF loads upper/FE.
- R6: A fetch in $0FD0-$0FDF sets latch 0 to FD. A fetch in $0FE0-$0FEF sets it to FE.
- R7: A fetch in $1FD0-$1FDF sets latch 1 to FD. A fetch in $1FE0-$1FEF sets it to FE.
- R8: Fetches in $0000-$0FFF output {lower bank picked by latch 0, A11:0}, and fetches in $1000-$1FFF output {upper bank picked by latch 1, A11:0}. A triggering fetch still uses the old bank. The new bank applies from the next fetch on.
- R9: Fetches outside the four trigger windows leave both latches unchanged. This includes addresses with A13 set and trigger windows of the other half.
- R10: A write in $F000-$FFFF loads data bit 0 as mirroring. ciram_a10_o equals PPU A10 when the bit is 0 and PPU A11 when it is 1.
- R11: CPU writes below $A000 and cycles with cpu_wr_i low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| prg_rom_addr_o | output | 18 | Program ROM address |
| prg_rom_ce_o | output | 1 | Program ROM enable |
| prg_ram_addr_o | output | 13 | Program RAM address |
| prg_ram_ce_o | output | 1 | Program RAM enable |
| ppu_addr_i | input | 14 | Picture bus address |
| ppu_rd_i | input | 1 | Pattern fetch strobe, one cycle per fetch |
| chr_addr_o | output | 17 | Character ROM address |
| ciram_a10_o | output | 1 | Nametable RAM A10 |

## Verification
Bank selection is exercised in three ways. Directed fetch sequences step each latch through FD and FE, which separates the triggering fetch from the one after it and isolates each half. Near-miss addresses ($0FCF, $0FF0, $2FD0, and the other half's windows) test whether the decode is too wide. A seeded random mix of register writes, CPU probes and fetches, biased toward the trigger windows, then compares every output against a bench model. That mix catches wrong register indexing, lost data masking and latch cross-talk that the directed cases can miss.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int CPU_AW = 16;
  localparam int PPU_AW = 14;
  localparam int WIN_AW = 14;   // 16 KB program window
  localparam int RAM_AW = 13;   // 8 KB program RAM
  localparam int TILE_AW = 12;  // 4 KB pattern half

  typedef enum logic {
    LATCH_FD = 1'b0,
    LATCH_FE = 1'b1
  } latch_e;

  localparam logic [7:0] TILE_FD = 8'hFD;
  localparam logic [7:0] TILE_FE = 8'hFE;
endpackage

// File: rtl/tbm_cpu_regs.sv
module tbm_cpu_regs #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5,
  parameter int NUM_CHR    = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [3:0]                          page_i,
  input  logic [7:0]                          data_i,
  input  logic                                wr_i,
  output logic [PRG_BANK_W-1:0]               prg_bank_o,
  output logic [NUM_CHR-1:0][CHR_BANK_W-1:0]  chr_bank_o,
  output logic                                mirror_h_o
);
  localparam logic [3:0] PAGE_PRG = 4'hA;
  localparam logic [3:0] PAGE_MIR = 4'hF;
  localparam int         CHR_BASE = 11;  // first CHR page $B

  logic unused_data;
  assign unused_data = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_bank_o <= '0;
      mirror_h_o <= 1'b0;
    end else if (wr_i) begin
      if (page_i == PAGE_PRG) prg_bank_o <= data_i[PRG_BANK_W-1:0];
      if (page_i == PAGE_MIR) mirror_h_o <= data_i[0];
    end
  end

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
    localparam logic [3:0] SEL = 4'(CHR_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    chr_bank_o[g] <= '0;
      else if (wr_i && page_i == SEL) chr_bank_o[g] <= data_i[CHR_BANK_W-1:0];
    end
  end
endmodule

// File: rtl/tbm_tile_latch.sv
module tbm_tile_latch #(
  parameter logic HALF = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [tbm_pkg::PPU_AW-1:0]    ppu_addr_i,
  input  logic                          ppu_rd_i,
  output tbm_pkg::latch_e               state_o
);
  import tbm_pkg::*;

  logic       in_half;
  logic [7:0] tile;

  assign in_half = ppu_rd_i && !ppu_addr_i[13] && (ppu_addr_i[12] == HALF);
  assign tile    = ppu_addr_i[11:4];

  // updates after the fetch edge, so the triggering fetch sees the old bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= LATCH_FE;
    else if (in_half && tile == TILE_FD) state_o <= LATCH_FD;
    else if (in_half && tile == TILE_FE) state_o <= LATCH_FE;
  end
endmodule

// File: rtl/tbm_prg_map.sv
module tbm_prg_map #(
  parameter int PRG_BANK_W = 4
) (
  input  logic [tbm_pkg::CPU_AW-1:0]               cpu_addr_i,
  input  logic [PRG_BANK_W-1:0]                    prg_bank_i,
  output logic [PRG_BANK_W+tbm_pkg::WIN_AW-1:0]    rom_addr_o,
  output logic                                     rom_ce_o,
  output logic [tbm_pkg::RAM_AW-1:0]               ram_addr_o,
  output logic                                     ram_ce_o
);
  import tbm_pkg::*;

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

  logic [PRG_BANK_W-1:0] bank;

  always_comb begin
    bank       = cpu_addr_i[14] ? LAST_BANK : prg_bank_i;
    rom_addr_o = {bank, cpu_addr_i[WIN_AW-1:0]};
    rom_ce_o   = cpu_addr_i[15];
    ram_ce_o   = (cpu_addr_i[15:13] == 3'b011);
    ram_addr_o = cpu_addr_i[RAM_AW-1:0];
  end
endmodule

// File: rtl/tile_bank_mapper.sv
module tile_bank_mapper #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5,
  localparam int PRG_AW = PRG_BANK_W + tbm_pkg::WIN_AW,
  localparam int CHR_AW = CHR_BANK_W + tbm_pkg::TILE_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_wr_i,
  output logic [PRG_AW-1:0] prg_rom_addr_o,
  output logic              prg_rom_ce_o,
  output logic [12:0]       prg_ram_addr_o,
  output logic              prg_ram_ce_o,
  input  logic [13:0]       ppu_addr_i,
  input  logic              ppu_rd_i,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic              ciram_a10_o
);
  import tbm_pkg::*;

  localparam int NUM_HALF = 2;
  localparam int NUM_CHR  = 2 * NUM_HALF;

  logic [PRG_BANK_W-1:0]               prg_bank;
  logic [NUM_CHR-1:0][CHR_BANK_W-1:0]  chr_bank;
  logic                                mirror_h;
  latch_e                              lat_st [NUM_HALF];
  logic [CHR_BANK_W-1:0]               half_bank [NUM_HALF];

  tbm_cpu_regs #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_BANK_W (CHR_BANK_W),
    .NUM_CHR    (NUM_CHR)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .page_i     (cpu_addr_i[15:12]),
    .data_i     (cpu_data_i),
    .wr_i       (cpu_wr_i),
    .prg_bank_o (prg_bank),
    .chr_bank_o (chr_bank),
    .mirror_h_o (mirror_h)
  );

  tbm_prg_map #(
    .PRG_BANK_W (PRG_BANK_W)
  ) i_prg (
    .cpu_addr_i (cpu_addr_i),
    .prg_bank_i (prg_bank),
    .rom_addr_o (prg_rom_addr_o),
    .rom_ce_o   (prg_rom_ce_o),
    .ram_addr_o (prg_ram_addr_o),
    .ram_ce_o   (prg_ram_ce_o)
  );

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    tbm_tile_latch #(
      .HALF (1'(h))
    ) i_latch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ppu_addr_i (ppu_addr_i),
      .ppu_rd_i   (ppu_rd_i),
      .state_o    (lat_st[h])
    );
    // register pair per half: FD at 2h, FE at 2h+1
    assign half_bank[h] = (lat_st[h] == LATCH_FD) ? chr_bank[2*h] : chr_bank[2*h+1];
  end

  assign chr_addr_o  = {half_bank[ppu_addr_i[12]], ppu_addr_i[TILE_AW-1:0]};
  assign ciram_a10_o = mirror_h ? ppu_addr_i[11] : ppu_addr_i[10];
endmodule

// File: rtl/tbm_checker.sv
module tbm_checker #(
  parameter int PRG_BANK_W = 4,
  parameter int PRG_AW     = 18
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [15:0]           cpu_addr_i,
  input logic                  cpu_wr_i,
  input logic [PRG_AW-1:0]     prg_rom_addr_o,
  input logic                  prg_rom_ce_o,
  input logic                  prg_ram_ce_o,
  input logic [13:0]           ppu_addr_i,
  input logic                  ppu_rd_i,
  input logic                  lat0_i,
  input logic                  lat1_i,
  input logic [PRG_BANK_W-1:0] prg_bank_i
);
  p_fixed_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:14] == 2'b11 |-> prg_rom_addr_o[PRG_AW-1 -: PRG_BANK_W] == '1);

  p_ce_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prg_ram_ce_o && prg_rom_ce_o));

  p_ram_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_ram_ce_o |-> cpu_addr_i[15:13] == 3'b011);

  p_lat0_fd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_rd_i && ppu_addr_i[13:4] == 10'h0FD |=> lat0_i == 1'b0);

  p_lat0_fe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_rd_i && ppu_addr_i[13:4] == 10'h0FE |=> lat0_i == 1'b1);

  p_lat1_fd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_rd_i && ppu_addr_i[13:4] == 10'h1FD |=> lat1_i == 1'b0);

  p_lat1_fe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_rd_i && ppu_addr_i[13:4] == 10'h1FE |=> lat1_i == 1'b1);

  p_lat_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ppu_rd_i |=> $stable(lat0_i) && $stable(lat1_i));

  p_prg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_wr_i |=> $stable(prg_bank_i));
endmodule

bind tile_bank_mapper tbm_checker #(
  .PRG_BANK_W (PRG_BANK_W),
  .PRG_AW     (PRG_AW)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_addr_i     (cpu_addr_i),
  .cpu_wr_i       (cpu_wr_i),
  .prg_rom_addr_o (prg_rom_addr_o),
  .prg_rom_ce_o   (prg_rom_ce_o),
  .prg_ram_ce_o   (prg_ram_ce_o),
  .ppu_addr_i     (ppu_addr_i),
  .ppu_rd_i       (ppu_rd_i),
  .lat0_i         (lat_st[0]),
  .lat1_i         (lat_st[1]),
  .prg_bank_i     (prg_bank)
);

// File: tb/test_tile_bank_mapper.sv
`timescale 1ns/1ps
module test_tile_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [17:0] prg_rom_addr_o;
  logic        prg_rom_ce_o;
  logic [12:0] prg_ram_addr_o;
  logic        prg_ram_ce_o;
  logic [13:0] ppu_addr_i = '0;
  logic        ppu_rd_i = 1'b0;
  logic [16:0] chr_addr_o;
  logic        ciram_a10_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [3:0] m_prg;
  logic [4:0] m_chr [4];
  logic       m_mir;
  bit         m_fd [2];

  tile_bank_mapper i_tile_bank_mapper (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_chr(input logic [13:0] a);
    logic [4:0] b;
    if (a[12]) b = m_fd[1] ? m_chr[2] : m_chr[3];
    else       b = m_fd[0] ? m_chr[0] : m_chr[1];
    return {b, a[11:0]};
  endfunction

  function automatic logic [17:0] exp_rom(input logic [15:0] a);
    return {a[14] ? 4'hF : m_prg, a[13:0]};
  endfunction

  task automatic model_reset();
    m_prg = '0; m_mir = 1'b0;
    for (int i = 0; i < 4; i++) m_chr[i] = '0;
    m_fd[0] = 1'b0; m_fd[1] = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = 1'b1;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    case (a[15:12])
      4'hA: m_prg = d[3:0];
      4'hB, 4'hC, 4'hD, 4'hE: m_chr[a[15:12] - 4'hB] = d[4:0];
      4'hF: m_mir = d[0];
      default: ;
    endcase
  endtask

  task automatic cpu_probe(input logic [15:0] a, input string tag);
    @(negedge clk_i);
    cpu_addr_i = a;
    #1;
    chk({tag, " rom_ce"}, prg_rom_ce_o, a[15]);
    chk({tag, " ram_ce"}, prg_ram_ce_o, a[15:13] == 3'b011);
    if (a[15]) chk({tag, " rom_addr"}, prg_rom_addr_o, exp_rom(a));
    if (a[15:13] == 3'b011) chk({tag, " ram_addr"}, prg_ram_addr_o, a[12:0]);
  endtask

  task automatic ppu_fetch(input logic [13:0] a, input string tag);
    @(negedge clk_i);
    ppu_addr_i = a; ppu_rd_i = 1'b1;
    #1;
    chk({tag, " chr_addr"}, chr_addr_o, exp_chr(a));
    chk({tag, " ciram"}, ciram_a10_o, m_mir ? a[11] : a[10]);
    @(negedge clk_i);
    ppu_rd_i = 1'b0;
    if (!a[13] && a[11:4] == 8'hFD) m_fd[a[12]] = 1'b1;
    if (!a[13] && a[11:4] == 8'hFE) m_fd[a[12]] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    cpu_probe(16'h8123, "R1");
    ppu_fetch(14'h0123, "R1");
    ppu_fetch(14'h1456, "R1");
    ppu_fetch(14'h0400, "R1");  // vertical: ciram = A10 = 1

    // R3 fixed top bank
    cpu_probe(16'hC000, "R3");
    cpu_probe(16'hFFFF, "R3");

    // R2 prg bank, high data bits ignored
    cpu_write(16'hA7FF, 8'hF9);
    cpu_probe(16'h8000, "R2");
    cpu_probe(16'hBFFF, "R2");
    chk("R2 masked bank", prg_rom_addr_o[17:14], 4'h9);
    cpu_probe(16'hE234, "R3");

    // R4 enables
    cpu_probe(16'h6000, "R4");
    cpu_probe(16'h7ABC, "R4");
    cpu_probe(16'h5FFF, "R4");
    cpu_probe(16'h0000, "R4");

    // R11 writes below $A000 ignored
    cpu_write(16'h8000, 8'h03);
    cpu_write(16'h9FFF, 8'h05);
    cpu_write(16'h6000, 8'h1F);
    cpu_probe(16'h8000, "R11");
    chk("R11 bank kept", prg_rom_addr_o[17:14], 4'h9);

    // R5 chr registers, bits 7:5 ignored
    cpu_write(16'hB000, 8'hE3);
    cpu_write(16'hCFFF, 8'h07);
    cpu_write(16'hD555, 8'h2A);
    cpu_write(16'hE001, 8'hF1);
    ppu_fetch(14'h0010, "R5");   // latch 0 FE -> reg C
    ppu_fetch(14'h1010, "R5");   // latch 1 FE -> reg E

    // R8 triggering fetch uses old bank; R6 latch 0
    ppu_fetch(14'h0FD5, "R8");
    ppu_fetch(14'h0020, "R6");
    chk("R6 lower FD bank", chr_addr_o[16:12], 5'h03);
    ppu_fetch(14'h0FEF, "R8");
    ppu_fetch(14'h0030, "R6");

    // R7 latch 1
    ppu_fetch(14'h1FD0, "R8");
    ppu_fetch(14'h1040, "R7");
    chk("R7 upper FD bank", chr_addr_o[16:12], 5'h0A);
    ppu_fetch(14'h1FE8, "R7");
    ppu_fetch(14'h1050, "R7");

    // R9 near misses do not move latches
    ppu_fetch(14'h0FCF, "R9");
    ppu_fetch(14'h0FF0, "R9");
    ppu_fetch(14'h2FD0, "R9");
    ppu_fetch(14'h1FD3, "R9");   // upper trigger, lower must stay FE
    ppu_fetch(14'h0060, "R9");
    chk("R9 lower kept FE", chr_addr_o[16:12], 5'h07);

    // R10 mirroring
    cpu_write(16'hF000, 8'hFF);
    ppu_fetch(14'h2800, "R10");
    ppu_fetch(14'h2400, "R10");
    cpu_write(16'hFABC, 8'h02);
    ppu_fetch(14'h2400, "R10");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [15:0] a = 16'($urandom);
        if ($urandom_range(0, 1) == 1) a[15:12] = 4'(10 + $urandom_range(0, 5));
        cpu_write(a, 8'($urandom));
      end else if (op == 1) begin
        cpu_probe(16'($urandom), "R2");
      end else begin
        logic [13:0] a = 14'($urandom);
        if ($urandom_range(0, 2) != 0)
          a = {1'b0, 1'($urandom), 8'($urandom_range(8'hFC, 8'hFF)), 4'($urandom)};
        ppu_fetch(a, "R8");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule